// File: doc/BRIEF.md
# Byte FIFO Pair with Event and Interrupt Logic

This block sits between a processor-facing register port and a serial shift engine. It holds two byte queues of 32 entries each. The transmit queue is filled by the processor and drained one byte at a time by the shifter. The receive queue is filled one byte at a time by the shifter and drained by the processor. Each queue is reached through one data address. An access there moves one, two or four bytes according to the access size. Multi-byte accesses are big-endian: the most significant byte of the accessed field enters or leaves the queue first.

An event word reports the live receive byte count and the transmit free space. It also holds a set of sticky status flags, which software clears by writing ones. A mask word selects which flags drive the interrupt line. A mode word holds the transmit and receive thresholds that the two threshold flags compare against. The shifter is represented by plain byte ports: a byte-take strobe with a registered byte output, a byte-push strobe with a byte input, and a one-cycle "transfer finished" pulse.

Top module: `byte_fifo_pair`

## Requirements
- R1: After reset the mode word reads 0x0000040F (TX threshold 4 in bits 13:8, RX threshold 15 in bits 5:0). Once the flags settle, the event word reads 0x00208900: TX free space 32 in bits 21:16, RX count 0 in bits 29:24, and flags TX-empty (bit 15), TX-above-threshold (bit 11) and TX-not-full (bit 8) set. The interrupt is low.
- R2: Word address 3 is TX data. The access size is 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. A write there pushes that many bytes, taken from the low 8, 16 or 32 bits of the write data, and the TX free space drops by the same amount.
- R3: Bytes pushed to the TX queue leave on the serial side in big-endian order. A take strobe presents the head byte on the byte output, with its valid bit set, one cycle later.
- R4: Word address 4 is RX data. A read there pops 1, 2 or 4 bytes and returns them right-aligned, with the oldest byte most significant and the unused upper bits zero. The RX count drops by the same amount.
- R5: A TX push of k bytes when fewer than k bytes are free is ignored, and the queue's contents and count stay unchanged. A take on an empty TX queue returns no valid byte.
- R6: An RX pop of k bytes when fewer than k bytes are stored is ignored. It returns zero and leaves the count unchanged.
- R7: The mode word at address 0 sets the TX threshold (bits 13:8) and the RX threshold (bits 5:0). Flag bit 13 sets while the RX count is greater than the RX threshold. Flag bit 11 sets while the TX free space is greater than the TX threshold.
- R8: Flag bit 12 sets while the RX queue is full and flag bit 9 sets while it is not empty. Flag bit 15 sets while the TX queue is empty and flag bit 8 sets while it is not full. Every flag is sticky. Bit 10 always reads 0.
- R9: Writing ones to the event word at address 1 clears the matching flags. A flag whose condition still holds sets again on the next cycle.
- R10: A pulse on the transfer-finished input sets flag bit 14.
- R11: The mask word at address 2 uses the flag bit positions. The interrupt output is high one cycle after any flag and its mask bit are both set, and low one cycle after no such pair remains.
- R12: A serial byte that arrives while the RX queue is full is dropped.
- R13: A processor access and a serial transfer on the same queue in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address: 0 mode, 1 event, 2 mask, 3 TX data, 4 RX data |
| bus_size | input | 2 | Access size: 0 byte, 1 two bytes, 2/3 four bytes |
| bus_wdata | input | 32 | Write data, right-aligned for narrow accesses |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| tx_take | input | 1 | Shifter requests one TX byte |
| tx_byte | output | 8 | TX byte handed to the shifter |
| tx_byte_valid | output | 1 | tx_byte holds a byte taken in the previous cycle |
| rx_strobe | input | 1 | Shifter delivers one RX byte |
| rx_byte | input | 8 | RX byte from the shifter |
| xfer_done | input | 1 | Transfer finished pulse |
| irq | output | 1 | Interrupt request, registered |

## Verification
On every cycle the in-line properties check four things: no queue level goes above its depth; a push without room leaves the level as it was; a short RX pop returns zero; and a dropped serial byte keeps a full RX queue full. They also check that the transfer pulse sets its flag and that the interrupt follows the masked flags one cycle later. Only the directed scenarios can show the byte ordering of mixed-width accesses, the exact layout of the event word, and the threshold comparisons against programmed values. The same holds for the sticky-then-cleared life of each flag and for same-cycle access from both sides.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int CNT_W = 6;

  localparam logic [2:0] REG_MODE   = 3'd0;
  localparam logic [2:0] REG_EVENT  = 3'd1;
  localparam logic [2:0] REG_MASK   = 3'd2;
  localparam logic [2:0] REG_TXDATA = 3'd3;
  localparam logic [2:0] REG_RXDATA = 3'd4;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_ALT  = 2'd3
  } acc_size_e;

  // flag indices inside the 8-bit flag vector (event word bits 15:8)
  localparam int FL_TNF = 0;
  localparam int FL_RNE = 1;
  localparam int FL_RSV = 2;
  localparam int FL_TXT = 3;
  localparam int FL_RXF = 4;
  localparam int FL_RXT = 5;
  localparam int FL_DON = 6;
  localparam int FL_TXE = 7;

  localparam logic [CNT_W-1:0] TXTHR_RST = 6'd4;
  localparam logic [CNT_W-1:0] RXTHR_RST = 6'd15;

  function automatic logic [2:0] acc_bytes(acc_size_e s);
    case (s)
      ACC_BYTE: acc_bytes = 3'd1;
      ACC_HALF: acc_bytes = 3'd2;
      default:  acc_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bfp_byte_fifo.sv
module bfp_byte_fifo #(
  parameter int DEPTH      = 32,
  parameter int BANKS      = 4,
  parameter int PUSH_LANES = 4,
  parameter int POP_LANES  = 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 push_req,
  input  logic [$clog2(PUSH_LANES+1)-1:0]      push_cnt,
  input  logic [8*PUSH_LANES-1:0]              push_data,
  input  logic                                 pop_req,
  input  logic [$clog2(POP_LANES+1)-1:0]       pop_cnt,
  output logic [8*POP_LANES-1:0]               pop_data,
  output logic [$clog2(DEPTH+1)-1:0]           level
);
  localparam int AW   = $clog2(DEPTH);
  localparam int LW   = $clog2(BANKS);
  localparam int RW   = AW - LW;
  localparam int ROWS = DEPTH / BANKS;
  localparam int CW   = $clog2(DEPTH+1);
  localparam int DW   = 8 * POP_LANES;

  logic [7:0]    mem [BANKS][ROWS];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] level_q, room;
  logic          push_ok, pop_ok;

  assign room    = CW'(DEPTH) - level_q;
  assign push_ok = push_req && (push_cnt != '0) && (CW'(push_cnt) <= room);
  assign pop_ok  = pop_req && (pop_cnt != '0) && (CW'(pop_cnt) <= level_q);
  assign level   = level_q;

  // write steering: byte j of a push lands in bank (wptr+j) mod BANKS
  logic [BANKS-1:0] wen;
  logic [RW-1:0]    wrow  [BANKS];
  logic [7:0]       wbyte [BANKS];

  always_comb begin
    logic [AW-1:0] ws;
    wen = '0;
    for (int b = 0; b < BANKS; b++) begin
      wrow[b]  = '0;
      wbyte[b] = '0;
    end
    for (int j = 0; j < PUSH_LANES; j++) begin
      ws = wptr + AW'(j);
      if (push_ok && (j < int'(push_cnt))) begin
        wen[ws[LW-1:0]]   = 1'b1;
        wrow[ws[LW-1:0]]  = ws[AW-1:LW];
        wbyte[ws[LW-1:0]] = 8'(push_data >> (8 * (int'(push_cnt) - 1 - j)));
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++) begin
      if (wen[b]) mem[b][wrow[b]] <= wbyte[b];
    end
  end

  // read gather: oldest byte ends up most significant
  always_comb begin
    logic [AW-1:0] rs;
    pop_data = '0;
    for (int j = 0; j < POP_LANES; j++) begin
      rs = rptr + AW'(j);
      if (pop_ok && (j < int'(pop_cnt)))
        pop_data = (pop_data << 8) | DW'(mem[rs[LW-1:0]][rs[AW-1:LW]]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(push_cnt);
      if (pop_ok)  rptr <= rptr + AW'(pop_cnt);
      level_q <= level_q + (push_ok ? CW'(push_cnt) : '0) - (pop_ok ? CW'(pop_cnt) : '0);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level_q <= CW'(DEPTH)); // R5

  AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push_req && (CW'(push_cnt) > room) && !pop_req) |=> (level_q == $past(level_q))); // R5

  AST_SHORT_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop_req && (CW'(pop_cnt) > level_q)) |-> (pop_data == '0)); // R6
endmodule

// File: rtl/bfp_event_unit.sv
module bfp_event_unit
  import bfp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [CNT_W-1:0] tx_thr_in,
  input  logic [CNT_W-1:0] rx_thr_in,
  input  logic             evt_we,
  input  logic [7:0]       evt_clr,
  input  logic             mask_we,
  input  logic [7:0]       mask_in,
  input  logic [CW-1:0]    tx_level,
  input  logic [CW-1:0]    rx_level,
  input  logic             xfer_done,
  output logic [CNT_W-1:0] tx_thr,
  output logic [CNT_W-1:0] rx_thr,
  output logic [7:0]       flags,
  output logic [7:0]       mask,
  output logic             irq
);
  localparam logic [7:0] FLAG_IMPL = 8'hFF & ~(8'h1 << FL_RSV);

  logic [CNT_W-1:0] tx_thr_q, rx_thr_q;
  logic [7:0]       flags_q, mask_q, cond, clr;
  logic [CW-1:0]    tx_free;
  logic             irq_q;

  assign tx_free = CW'(DEPTH) - tx_level;

  always_comb begin
    cond         = '0;
    cond[FL_TXE] = (tx_level == '0);
    cond[FL_DON] = xfer_done;
    cond[FL_RXT] = (rx_level > CW'(rx_thr_q));
    cond[FL_RXF] = (rx_level == CW'(DEPTH));
    cond[FL_TXT] = (tx_free > CW'(tx_thr_q));
    cond[FL_RNE] = (rx_level != '0);
    cond[FL_TNF] = (tx_level != CW'(DEPTH));
  end

  assign clr = evt_we ? evt_clr : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr_q <= TXTHR_RST;
      rx_thr_q <= RXTHR_RST;
      flags_q  <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (mode_we) begin
        tx_thr_q <= tx_thr_in;
        rx_thr_q <= rx_thr_in;
      end
      if (mask_we) mask_q <= mask_in & FLAG_IMPL;
      flags_q <= ((flags_q & ~clr) | cond) & FLAG_IMPL;
      irq_q   <= |(flags_q & mask_q);
    end
  end

  assign tx_thr = tx_thr_q;
  assign rx_thr = rx_thr_q;
  assign flags  = flags_q;
  assign mask   = mask_q;
  assign irq    = irq_q;

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> flags_q[FL_DON]); // R10

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(flags_q & mask_q)) |=> irq_q); // R11

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(flags_q & mask_q)) |=> !irq_q); // R11

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    !flags_q[FL_RSV]); // R8
endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair
  import bfp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int BANKS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [2:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic        tx_take,
  output logic [7:0]  tx_byte,
  output logic        tx_byte_valid,
  input  logic        rx_strobe,
  input  logic [7:0]  rx_byte,
  input  logic        xfer_done,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [2:0]       acc_n;
  logic             wr, rd;
  logic             tx_push, rx_pop;
  logic [CW-1:0]    tx_level, rx_level;
  logic [7:0]       tx_pop_data;
  logic [31:0]      rx_pop_data;
  logic [CNT_W-1:0] tx_thr, rx_thr;
  logic [7:0]       flags, mask;
  logic [CNT_W-1:0] tx_free_f, rx_cnt_f;
  logic [31:0]      rd_mux;
  logic [7:0]       tx_byte_q;
  logic             tx_byte_vq;

  assign acc_n   = acc_bytes(acc_size_e'(bus_size));
  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign tx_push = wr && (bus_addr == REG_TXDATA);
  assign rx_pop  = rd && (bus_addr == REG_RXDATA);

  bfp_byte_fifo #(
    .DEPTH(DEPTH), .BANKS(BANKS), .PUSH_LANES(4), .POP_LANES(1)
  ) i_tx_fifo (
    .clk(clk), .rst(rst),
    .push_req(tx_push), .push_cnt(acc_n), .push_data(bus_wdata),
    .pop_req(tx_take), .pop_cnt(1'b1), .pop_data(tx_pop_data),
    .level(tx_level)
  );

  bfp_byte_fifo #(
    .DEPTH(DEPTH), .BANKS(BANKS), .PUSH_LANES(1), .POP_LANES(4)
  ) i_rx_fifo (
    .clk(clk), .rst(rst),
    .push_req(rx_strobe), .push_cnt(1'b1), .push_data(rx_byte),
    .pop_req(rx_pop), .pop_cnt(acc_n), .pop_data(rx_pop_data),
    .level(rx_level)
  );

  bfp_event_unit #(.DEPTH(DEPTH), .CW(CW)) i_events (
    .clk(clk), .rst(rst),
    .mode_we(wr && (bus_addr == REG_MODE)),
    .tx_thr_in(bus_wdata[13:8]), .rx_thr_in(bus_wdata[5:0]),
    .evt_we(wr && (bus_addr == REG_EVENT)), .evt_clr(bus_wdata[15:8]),
    .mask_we(wr && (bus_addr == REG_MASK)), .mask_in(bus_wdata[15:8]),
    .tx_level(tx_level), .rx_level(rx_level), .xfer_done(xfer_done),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .flags(flags), .mask(mask), .irq(irq)
  );

  assign tx_free_f = CNT_W'(CW'(DEPTH) - tx_level);
  assign rx_cnt_f  = CNT_W'(rx_level);

  always_comb begin
    case (bus_addr)
      REG_MODE:   rd_mux = {18'b0, tx_thr, 2'b0, rx_thr};
      REG_EVENT:  rd_mux = {2'b0, rx_cnt_f, 2'b0, tx_free_f, flags, 8'h00};
      REG_MASK:   rd_mux = {16'b0, mask, 8'h00};
      REG_RXDATA: rd_mux = rx_pop_data;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_byte_q  <= '0;
      tx_byte_vq <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
      tx_byte_vq <= tx_take && (tx_level != '0);
      if (tx_take) tx_byte_q <= tx_pop_data;
    end
  end

  assign tx_byte       = tx_byte_q;
  assign tx_byte_valid = tx_byte_vq;

  AST_RX_DROP_FULL: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && (rx_level == CW'(DEPTH)) && !rx_pop) |=> (rx_level == CW'(DEPTH))); // R12

  AST_EMPTY_TAKE: assert property (@(posedge clk) disable iff (rst)
    (tx_take && (tx_level == '0)) |=> !tx_byte_valid); // R5
endmodule

// File: tb/test_byte_fifo_pair.sv
`timescale 1ns/100ps
module test_byte_fifo_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        tx_take = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_byte_valid;
  logic        rx_strobe = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        xfer_done = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  byte_fifo_pair i_byte_fifo_pair (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tx_take(tx_take),
    .tx_byte(tx_byte), .tx_byte_valid(tx_byte_valid), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .xfer_done(xfer_done), .irq(irq)
  );

  localparam logic [2:0] A_MODE = 3'd0, A_EVT = 3'd1, A_MASK = 3'd2, A_TX = 3'd3, A_RX = 3'd4;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input logic w, input logic [2:0] a, input logic [1:0] s,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    q = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, s, d, q);
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] q);
    bus(1'b0, a, s, 32'h0, q);
  endtask

  task automatic ev(output logic [31:0] q);
    idle(2);
    rd(A_EVT, 2'd2, q);
  endtask

  task automatic clear_ev();
    wr(A_EVT, 2'd2, 32'hFFFF_FFFF);
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_strobe = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic take(output logic v, output logic [7:0] b);
    @(negedge clk);
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
    v = tx_byte_valid; b = tx_byte;
  endtask

  task automatic t_reset();
    logic [31:0] q;
    chk("R1 irq low after reset", {31'b0, irq}, 32'h0);
    rd(A_MODE, 2'd2, q);
    chk("R1 mode word reset", q, 32'h0000_040F);
    ev(q);
    chk("R1 event word reset", q, 32'h0020_8900);
  endtask

  task automatic t_push_sizes();
    logic [31:0] q;
    logic v; logic [7:0] b;
    logic [7:0] exp_b [7];
    exp_b = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    wr(A_TX, 2'd2, 32'h1122_3344);
    wr(A_TX, 2'd1, 32'hAAAA_5566);
    wr(A_TX, 2'd0, 32'hBBBB_BB77);
    ev(q);
    chk("R2 TX free after 4+2+1 bytes", {26'b0, q[21:16]}, 32'd25);
    for (int i = 0; i < 7; i++) begin
      take(v, b);
      chk("R3 TX byte valid", {31'b0, v}, 32'h1);
      chk("R3 TX big-endian order", {24'b0, b}, {24'b0, exp_b[i]});
    end
    ev(q);
    chk("R2 TX free restored", {26'b0, q[21:16]}, 32'd32);
  endtask

  task automatic t_rx_pop();
    logic [31:0] q;
    for (int i = 0; i < 8; i++) rx_send(8'hA0 + 8'(i));
    ev(q);
    chk("R4 RX count 8", {26'b0, q[29:24]}, 32'd8);
    rd(A_RX, 2'd2, q); chk("R4 RX word pop", q, 32'hA0A1_A2A3);
    rd(A_RX, 2'd1, q); chk("R4 RX half pop", q, 32'h0000_A4A5);
    rd(A_RX, 2'd0, q); chk("R4 RX byte pop", q, 32'h0000_00A6);
    ev(q);
    chk("R4 RX count 1", {26'b0, q[29:24]}, 32'd1);
    rd(A_RX, 2'd0, q); chk("R4 RX last byte", q, 32'h0000_00A7);
  endtask

  task automatic t_tx_full();
    logic [31:0] q;
    logic v; logic [7:0] b;
    for (int w = 0; w < 8; w++)
      wr(A_TX, 2'd2, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});
    clear_ev();
    ev(q);
    chk("R5 TX free 0 when full", {26'b0, q[21:16]}, 32'd0);
    chk("R9 TX-not-full cleared while full", {31'b0, q[8]}, 32'h0);
    wr(A_TX, 2'd2, 32'hDEAD_BEEF);
    wr(A_TX, 2'd0, 32'h0000_00EE);
    ev(q);
    chk("R5 push to full ignored", {26'b0, q[21:16]}, 32'd0);
    for (int i = 0; i < 32; i++) begin
      take(v, b);
      chk("R5 full TX contents intact", {23'b0, v, b}, {23'b0, 1'b1, 8'(i)});
    end
    take(v, b);
    chk("R5 take on empty TX", {31'b0, v}, 32'h0);
  endtask

  task automatic t_rx_short();
    logic [31:0] q;
    rd(A_RX, 2'd0, q);
    chk("R6 pop from empty returns zero", q, 32'h0);
    rx_send(8'hB0); rx_send(8'hB1);
    rd(A_RX, 2'd2, q);
    chk("R6 short word pop returns zero", q, 32'h0);
    ev(q);
    chk("R6 count unchanged after short pop", {26'b0, q[29:24]}, 32'd2);
    rd(A_RX, 2'd1, q);
    chk("R6 data kept after short pop", q, 32'h0000_B0B1);
  endtask

  task automatic t_thresholds();
    logic [31:0] q;
    logic v; logic [7:0] b;
    wr(A_MODE, 2'd2, 32'h0000_1E02);
    rd(A_MODE, 2'd2, q);
    chk("R7 mode readback", q, 32'h0000_1E02);
    clear_ev();
    ev(q);
    chk("R7 TX thr flag free 32 > 30", {31'b0, q[11]}, 32'h1);
    wr(A_TX, 2'd2, 32'h0102_0304);
    clear_ev();
    ev(q);
    chk("R7 TX thr flag free 28 <= 30", {31'b0, q[11]}, 32'h0);
    rx_send(8'h01); rx_send(8'h02);
    clear_ev();
    ev(q);
    chk("R7 RX thr flag count 2 <= 2", {31'b0, q[13]}, 32'h0);
    rx_send(8'h03);
    ev(q);
    chk("R7 RX thr flag count 3 > 2", {31'b0, q[13]}, 32'h1);
    for (int i = 0; i < 3; i++) rd(A_RX, 2'd0, q);
    for (int i = 0; i < 4; i++) take(v, b);
    wr(A_MODE, 2'd2, 32'h0000_040F);
  endtask

  task automatic t_flags();
    logic [31:0] q;
    clear_ev();
    for (int i = 0; i < 32; i++) rx_send(8'(i));
    rx_send(8'hEE);
    ev(q);
    chk("R12 RX count stays 32", {26'b0, q[29:24]}, 32'd32);
    chk("R8 RX full flag", {31'b0, q[12]}, 32'h1);
    chk("R8 RX not-empty flag", {31'b0, q[9]}, 32'h1);
    chk("R8 reserved bit 10", {31'b0, q[10]}, 32'h0);
    for (int w = 0; w < 8; w++) begin
      rd(A_RX, 2'd2, q);
      if (w == 7) chk("R12 dropped byte absent", q, 32'h1C1D_1E1F);
    end
    ev(q);
    chk("R8 RX not-empty sticky after drain", {31'b0, q[9]}, 32'h1);
    wr(A_EVT, 2'd2, 32'h0000_9200);
    ev(q);
    chk("R9 RX not-empty cleared", {31'b0, q[9]}, 32'h0);
    chk("R9 RX full cleared", {31'b0, q[12]}, 32'h0);
    chk("R9 TX empty re-set while true", {31'b0, q[15]}, 32'h1);
  endtask

  task automatic t_done_irq();
    logic [31:0] q;
    wr(A_MASK, 2'd2, 32'h0);
    clear_ev();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    ev(q);
    chk("R10 done flag set", {31'b0, q[14]}, 32'h1);
    chk("R11 irq low with mask 0", {31'b0, irq}, 32'h0);
    wr(A_MASK, 2'd2, 32'h0000_4000);
    rd(A_MASK, 2'd2, q);
    chk("R11 mask readback", q, 32'h0000_4000);
    idle(2);
    chk("R11 irq high on masked done", {31'b0, irq}, 32'h1);
    wr(A_EVT, 2'd2, 32'h0000_4000);
    idle(2);
    chk("R11 irq low after done cleared", {31'b0, irq}, 32'h0);
    wr(A_MASK, 2'd2, 32'h0000_8000);
    idle(2);
    chk("R11 irq high on masked TX empty", {31'b0, irq}, 32'h1);
    wr(A_MASK, 2'd2, 32'h0);
    idle(2);
    chk("R11 irq low after unmask", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_simul();
    logic [31:0] q;
    logic v; logic [7:0] b;
    wr(A_TX, 2'd1, 32'h0000_C0C1);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_TX; bus_size = 2'd2;
    bus_wdata = 32'hC2C3_C4C5; tx_take = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tx_take = 1'b0;
    chk("R13 TX take during push", {23'b0, tx_byte_valid, tx_byte}, {23'b0, 1'b1, 8'hC0});
    ev(q);
    chk("R13 TX free after push+take", {26'b0, q[21:16]}, 32'd27);
    for (int i = 0; i < 5; i++) take(v, b);
    for (int i = 0; i < 4; i++) rx_send(8'hD0 + 8'(i));
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = A_RX; bus_size = 2'd1;
    rx_strobe = 1'b1; rx_byte = 8'hD4;
    @(negedge clk);
    bus_valid = 1'b0; rx_strobe = 1'b0;
    chk("R13 RX pop during push", bus_rdata, 32'h0000_D0D1);
    ev(q);
    chk("R13 RX count after push+pop", {26'b0, q[29:24]}, 32'd3);
    rd(A_RX, 2'd2, q);
    chk("R13 RX short pop of 3 returns zero", q, 32'h0);
    rd(A_RX, 2'd1, q); chk("R13 RX remaining order", q, 32'h0000_D2D3);
    rd(A_RX, 2'd0, q); chk("R13 RX late byte", q, 32'h0000_00D4);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_push_sizes();
    t_rx_pop();
    t_tx_full();
    t_rx_short();
    t_thresholds();
    t_flags();
    t_done_irq();
    t_simul();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end
endmodule